// File: doc/BRIEF.md
# DMA Write Burst Request Controller

This block steers the outbound (local-to-host) direction of a bridge between a local DMA master and a PCI-style host bus. It watches status cycles snooped from the local bus. When one carries the start-of-write code, it fetches the transfer length once through a register-read handshake, and only then hands the local bus to the DMA master. The master fills an external FIFO. The block watches the FIFO level, the current host address and the cache line size, and decides when to ask for the host bus and which write command to use.

The block issues Memory Write and Invalidate only when at least one whole cache line is buffered and the address sits on a line boundary. While the local master still owns its bus, this is also the only case that raises a request. After the master lets go of the local bus, any buffered data is flushed, with a plain Memory Write whenever the line test fails. A line size of zero means a request as soon as one 32-bit word is buffered. Once the host bus is granted, the block drives data while the FIFO holds data. It gives the bus back when the FIFO runs dry. If the bus is taken away, the block re-requests and picks the command again from the fill level and address of that moment.

The length fetch is a valid/ready handshake. `len_rd_valid` stays high, unchanged, until `len_rd_ready` is seen in the same cycle, and `len_rd_data` is captured on that cycle. No other back-pressure exists. The host request and grant are a plain request/grant pair, and the other pins are level controls.

Top module: `dma_wr_burst_ctrl`

## Requirements
- R1: After reset, `len_rd_valid`, `local_grant`, `host_req` and `host_drive` are all low.
- R2: In the idle state, a cycle with `stat_valid` high and `stat_code` equal to 4'hA makes `len_rd_valid` high from the next cycle on. It stays high until a cycle with `len_rd_ready` high, and `local_grant` stays low meanwhile. Any other code is ignored.
- R3: In the cycle after `len_rd_valid` and `len_rd_ready` are both high, `local_grant` is high, `len_rd_valid` is low, and `xfer_len` holds the captured `len_rd_data`.
- R4: A start code seen while a transaction is active (fetching, local bus granted, or flushing) starts no new length read.
- R5: While `local_grant` is high and `line_words` is nonzero, `host_req` rises one cycle after `fifo_level >= line_words` and aligned both hold. Aligned means `dma_addr` modulo (4 × `line_words`) is zero. `host_cmd` is then 4'hF (Memory Write and Invalidate). With less than a line buffered, or an unaligned address, no request is made.
- R6: A `local_release` pulse makes `local_grant` low in the next cycle. From then on, any buffered data is requested for. The command is 4'hF if the fill is at least one line and the address is aligned, and 4'h7 (Memory Write) otherwise.
- R7: With `line_words` equal to zero, `host_req` rises one cycle after `fifo_level` becomes nonzero, with `host_cmd` equal to 4'h7.
- R8: `host_req` and `host_cmd` hold steady until `host_gnt`. In the next cycle, `host_req` is low and `host_drive` is high whenever `fifo_level` is nonzero.
- R9: While it owns the host bus, the block drives `host_drive` low at once when `fifo_level` is zero and gives the bus up. A `host_lost` pulse also ends ownership. The block then re-requests using the command chosen at the current address and fill.
- R10: After a release, the transaction ends once the FIFO is empty and the host bus is not owned or requested. A new start code is then accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_valid | input | 1 | Snooped local status cycle present |
| stat_code | input | 4 | Snooped status code (4'hA = write start) |
| len_rd_valid | output | 1 | Length register read request |
| len_rd_ready | input | 1 | Length read completes this cycle |
| len_rd_data | input | 16 | Length value returned by the read |
| xfer_len | output | 16 | Captured transfer length |
| local_grant | output | 1 | Local bus granted to the DMA master |
| local_release | input | 1 | Local master releases the bus (pulse) |
| fifo_level | input | 6 | 32-bit words buffered in the FIFO |
| dma_addr | input | 32 | Current host byte address |
| line_words | input | 8 | Cache line size in 32-bit words |
| host_req | output | 1 | Host bus request |
| host_gnt | input | 1 | Host bus granted |
| host_lost | input | 1 | Host bus taken away (pulse) |
| host_cmd | output | 4 | Write command for the burst |
| host_drive | output | 1 | Drive a data word this cycle |

## Verification
A phase register stuck in the wrong state shows within one cycle. Either `len_rd_valid` or `local_grant` fails to change after the start code, the handshake or the release, or a second length read appears mid-transaction. A wrong command latch or alignment test shows as a `host_cmd` value that differs from the line/alignment rule, on the very cycle `host_req` rises. A host sequencer that misses the grant, the empty FIFO or the loss shows in the next cycle as `host_req` and `host_drive` high together, or as a missing re-request.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_LOCAL = 2'd2,
    PH_FLUSH = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_OWN  = 2'd2
  } hstate_e;

  localparam logic [3:0] CMD_MEMWR  = 4'h7;
  localparam logic [3:0] CMD_MEMWRI = 4'hF;
endpackage

// File: rtl/dwb_phase_ctrl.sv
module dwb_phase_ctrl
  import dwb_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int LEN_W  = 16,
  parameter logic [CODE_W-1:0] START_CODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [CODE_W-1:0] stat_code,
  input  logic              len_rd_ready,
  input  logic [LEN_W-1:0]  len_rd_data,
  input  logic              local_release,
  input  logic              flush_done,
  output phase_e            phase,
  output logic [LEN_W-1:0]  len_q
);
  phase_e phase_n;
  logic   start_seen;

  assign start_seen = stat_valid && (stat_code == START_CODE);

  always_comb begin
    phase_n = phase;
    unique case (phase)
      PH_IDLE:  if (start_seen)    phase_n = PH_FETCH;
      PH_FETCH: if (len_rd_ready)  phase_n = PH_LOCAL;
      PH_LOCAL: if (local_release) phase_n = PH_FLUSH;
      PH_FLUSH: if (flush_done)    phase_n = PH_IDLE;
      default:                     phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      len_q <= '0;
    end else begin
      phase <= phase_n;
      if (phase == PH_FETCH && len_rd_ready) len_q <= len_rd_data;
    end
  end
endmodule

// File: rtl/dwb_cmd_policy.sv
module dwb_cmd_policy
  import dwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 6,
  parameter int LINE_W = 8
) (
  input  phase_e            phase,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LINE_W-1:0] line_words,
  output logic              want_bus,
  output logic [3:0]        want_cmd
);
  localparam int WADDR_W = ADDR_W - 2;
  localparam int CMP_W   = (LVL_W > LINE_W) ? LVL_W : LINE_W;

  logic               zero_line;
  logic               have_word;
  logic               full_line;
  logic               aligned;
  logic [WADDR_W-1:0] divisor;
  logic [WADDR_W-1:0] word_rem;
  logic [CMP_W-1:0]   lvl_x;
  logic [CMP_W-1:0]   line_x;

  assign zero_line = (line_words == '0);
  assign have_word = (fifo_level != '0);
  assign lvl_x     = CMP_W'(fifo_level);
  assign line_x    = CMP_W'(line_words);
  assign full_line = !zero_line && (lvl_x >= line_x);
  assign divisor   = zero_line ? WADDR_W'(1) : WADDR_W'(line_words);
  assign word_rem  = dma_addr[ADDR_W-1:2] % divisor;
  assign aligned   = (dma_addr[1:0] == 2'b00) && (word_rem == '0);

  always_comb begin
    want_bus = 1'b0;
    want_cmd = CMD_MEMWR;
    if (zero_line) begin
      want_bus = (phase == PH_LOCAL || phase == PH_FLUSH) && have_word;
      want_cmd = CMD_MEMWR;
    end else if (phase == PH_LOCAL) begin
      want_bus = full_line && aligned;
      want_cmd = CMD_MEMWRI;
    end else if (phase == PH_FLUSH) begin
      want_bus = have_word;
      want_cmd = (full_line && aligned) ? CMD_MEMWRI : CMD_MEMWR;
    end
  end
endmodule

// File: rtl/dwb_host_seq.sv
module dwb_host_seq
  import dwb_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_bus,
  input  logic [3:0]       want_cmd,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             host_gnt,
  input  logic             host_lost,
  output hstate_e          hstate,
  output logic [3:0]       cmd_q
);
  hstate_e hstate_n;

  always_comb begin
    hstate_n = hstate;
    unique case (hstate)
      HS_IDLE: if (want_bus) hstate_n = HS_REQ;
      HS_REQ:  if (host_gnt) hstate_n = HS_OWN;
      HS_OWN:  if (host_lost || fifo_level == '0) hstate_n = HS_IDLE;
      default: hstate_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hstate <= HS_IDLE;
      cmd_q  <= CMD_MEMWR;
    end else begin
      hstate <= hstate_n;
      if (hstate == HS_IDLE && want_bus) cmd_q <= want_cmd;
    end
  end
endmodule

// File: rtl/dma_wr_burst_ctrl.sv
module dma_wr_burst_ctrl
  import dwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LVL_W  = 6,
  parameter int LINE_W = 8,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] START_CODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [CODE_W-1:0] stat_code,
  output logic              len_rd_valid,
  input  logic              len_rd_ready,
  input  logic [LEN_W-1:0]  len_rd_data,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              local_grant,
  input  logic              local_release,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LINE_W-1:0] line_words,
  output logic              host_req,
  input  logic              host_gnt,
  input  logic              host_lost,
  output logic [3:0]        host_cmd,
  output logic              host_drive
);
  phase_e  phase;
  hstate_e hstate;
  logic    want_bus;
  logic [3:0] want_cmd;
  logic    flush_done;

  assign flush_done = (hstate == HS_IDLE) && !want_bus && (fifo_level == '0);

  dwb_phase_ctrl #(
    .CODE_W(CODE_W), .LEN_W(LEN_W), .START_CODE(START_CODE)
  ) u_phase (
    .clk(clk), .rst_n(rst_n),
    .stat_valid(stat_valid), .stat_code(stat_code),
    .len_rd_ready(len_rd_ready), .len_rd_data(len_rd_data),
    .local_release(local_release), .flush_done(flush_done),
    .phase(phase), .len_q(xfer_len)
  );

  dwb_cmd_policy #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .LINE_W(LINE_W)
  ) u_policy (
    .phase(phase), .fifo_level(fifo_level), .dma_addr(dma_addr),
    .line_words(line_words), .want_bus(want_bus), .want_cmd(want_cmd)
  );

  dwb_host_seq #(
    .LVL_W(LVL_W)
  ) u_host (
    .clk(clk), .rst_n(rst_n),
    .want_bus(want_bus), .want_cmd(want_cmd), .fifo_level(fifo_level),
    .host_gnt(host_gnt), .host_lost(host_lost),
    .hstate(hstate), .cmd_q(host_cmd)
  );

  assign len_rd_valid = (phase == PH_FETCH);
  assign local_grant  = (phase == PH_LOCAL);
  assign host_req     = (hstate == HS_REQ);
  assign host_drive   = (hstate == HS_OWN) && (fifo_level != '0);
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              len_rd_valid,
  input logic              len_rd_ready,
  input logic              local_grant,
  input logic              host_req,
  input logic              host_gnt,
  input logic [3:0]        host_cmd,
  input logic              host_drive,
  input logic [LINE_W-1:0] line_words
);
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    len_rd_valid && !len_rd_ready |=> len_rd_valid); // R2
  AST_NO_GRANT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    len_rd_valid |-> !local_grant); // R2
  AST_GRANT_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(local_grant) |-> $past(len_rd_valid && len_rd_ready)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_gnt |=> host_req && $stable(host_cmd)); // R8
  AST_REQ_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_drive)); // R8
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (host_cmd == 4'h7 || host_cmd == 4'hF)); // R6
  AST_ZERO_LINE_MW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_req) && $past(line_words) == '0 |-> host_cmd == 4'h7); // R7
  AST_LOCAL_MWI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_req) && $past(local_grant) && $past(line_words) != '0
      |-> host_cmd == 4'hF); // R5
endmodule

bind dma_wr_burst_ctrl dwb_checker #(.LINE_W(LINE_W)) u_dwb_checker (
  .clk(clk), .rst_n(rst_n),
  .len_rd_valid(len_rd_valid), .len_rd_ready(len_rd_ready),
  .local_grant(local_grant), .host_req(host_req), .host_gnt(host_gnt),
  .host_cmd(host_cmd), .host_drive(host_drive), .line_words(line_words)
);

// File: tb/dma_wr_burst_ctrl_bench.sv
module dma_wr_burst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_valid = 1'b0;
  logic [3:0]  stat_code = '0;
  logic        len_rd_valid;
  logic        len_rd_ready = 1'b0;
  logic [15:0] len_rd_data = '0;
  logic [15:0] xfer_len;
  logic        local_grant;
  logic        local_release = 1'b0;
  logic [5:0]  fifo_level = '0;
  logic [31:0] dma_addr = '0;
  logic [7:0]  line_words = 8'd4;
  logic        host_req;
  logic        host_gnt = 1'b0;
  logic        host_lost = 1'b0;
  logic [3:0]  host_cmd;
  logic        host_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_wr_burst_ctrl u_dma_wr_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_code(stat_code),
    .len_rd_valid(len_rd_valid), .len_rd_ready(len_rd_ready),
    .len_rd_data(len_rd_data), .xfer_len(xfer_len), .local_grant(local_grant),
    .local_release(local_release), .fifo_level(fifo_level), .dma_addr(dma_addr),
    .line_words(line_words), .host_req(host_req), .host_gnt(host_gnt),
    .host_lost(host_lost), .host_cmd(host_cmd), .host_drive(host_drive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_txn(logic [15:0] len);
    stat_valid = 1'b1; stat_code = 4'hA;
    tick();
    stat_valid = 1'b0; stat_code = 4'h0;
    chk("R2", "len_rd_valid after start", len_rd_valid, 1);
    tick();
    chk("R2", "len_rd_valid held", len_rd_valid, 1);
    chk("R2", "no grant while fetching", local_grant, 0);
    len_rd_ready = 1'b1; len_rd_data = len;
    tick();
    len_rd_ready = 1'b0;
    chk("R3", "grant after length", local_grant, 1);
    chk("R3", "len_rd_valid dropped", len_rd_valid, 0);
    chk("R3", "xfer_len", xfer_len, len);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    chk("R1", "len_rd_valid", len_rd_valid, 0);
    chk("R1", "local_grant", local_grant, 0);
    chk("R1", "host_req", host_req, 0);
    chk("R1", "host_drive", host_drive, 0);
  endtask

  task automatic t_other_code();
    stat_valid = 1'b1; stat_code = 4'h5;
    tick();
    stat_valid = 1'b0;
    tick();
    chk("R2", "other code ignored", len_rd_valid, 0);
  endtask

  task automatic t_local_line();
    start_txn(16'h0100);
    stat_valid = 1'b1; stat_code = 4'hA;
    tick();
    stat_valid = 1'b0;
    tick();
    chk("R4", "no second length read", len_rd_valid, 0);
    chk("R4", "grant kept", local_grant, 1);
    line_words = 8'd4; dma_addr = 32'h1000; fifo_level = 6'd3;
    tick(); tick();
    chk("R5", "no req below a line", host_req, 0);
    dma_addr = 32'h1004; fifo_level = 6'd8;
    tick(); tick();
    chk("R5", "no req unaligned", host_req, 0);
    dma_addr = 32'h1000; fifo_level = 6'd4;
    tick();
    chk("R5", "req on aligned full line", host_req, 1);
    chk("R5", "cmd MWI", host_cmd, 4'hF);
    tick();
    chk("R8", "req held before grant", host_req, 1);
    host_gnt = 1'b1;
    tick();
    host_gnt = 1'b0;
    chk("R8", "req low after grant", host_req, 0);
    chk("R8", "driving", host_drive, 1);
    fifo_level = 6'd0;
    #1;
    chk("R9", "drive low when empty", host_drive, 0);
    tick(); tick();
    chk("R9", "no re-request when empty", host_req, 0);
    fifo_level = 6'd4;
    tick();
    chk("R5", "second req", host_req, 1);
    host_gnt = 1'b1;
    tick();
    host_gnt = 1'b0;
    dma_addr = 32'h1004; host_lost = 1'b1;
    tick();
    host_lost = 1'b0;
    chk("R9", "bus lost stops drive", host_drive, 0);
    tick();
    chk("R9", "unaligned in local: no re-req", host_req, 0);
    local_release = 1'b1;
    tick();
    local_release = 1'b0;
    chk("R6", "grant low after release", local_grant, 0);
    tick();
    chk("R9", "re-request after loss", host_req, 1);
    chk("R6", "re-evaluated cmd MW", host_cmd, 4'h7);
    host_gnt = 1'b1;
    tick();
    host_gnt = 1'b0;
    chk("R8", "drive on flush", host_drive, 1);
    fifo_level = 6'd0;
    tick(); tick();
    chk("R10", "idle again", len_rd_valid, 0);
    start_txn(16'h0040);
  endtask

  task automatic t_flush_partial();
    line_words = 8'd3; dma_addr = 32'h000C; fifo_level = 6'd2;
    tick();
    chk("R5", "partial line no req", host_req, 0);
    local_release = 1'b1;
    tick();
    local_release = 1'b0;
    tick();
    chk("R6", "flush req", host_req, 1);
    chk("R6", "flush cmd MW", host_cmd, 4'h7);
    host_gnt = 1'b1;
    tick();
    host_gnt = 1'b0;
    fifo_level = 6'd0;
    tick(); tick();
    start_txn(16'h0008);
    fifo_level = 6'd3;
    tick();
    chk("R5", "line 3 aligned MWI", host_cmd, 4'hF);
    chk("R5", "line 3 req", host_req, 1);
    host_gnt = 1'b1;
    tick();
    host_gnt = 1'b0;
    fifo_level = 6'd0;
    local_release = 1'b1;
    tick();
    local_release = 1'b0;
    tick(); tick();
  endtask

  task automatic t_zero_line();
    line_words = 8'd0; dma_addr = 32'h0002_0010; fifo_level = 6'd0;
    start_txn(16'h0004);
    tick();
    chk("R7", "no req when empty", host_req, 0);
    fifo_level = 6'd1;
    tick();
    chk("R7", "req on one word", host_req, 1);
    chk("R7", "cmd MW", host_cmd, 4'h7);
  endtask

  initial begin
    t_reset();
    t_other_code();
    t_local_line();
    t_flush_partial();
    t_zero_line();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule